// File: doc/BRIEF.md
# Sensor-Actuator Bus Slave Engine

This block is the digital core of a slave node on a two-wire, master-polled sensor/actuator bus. It receives an already demodulated, oversampled line signal, decodes Manchester II symbols into 14-bit master calls, and checks the framing and parity of each call. It also compares the address in the call with the node's own address. When a data-exchange call is valid and addressed to this node, the block stores the call's 4-bit output nibble for the application. After a fixed pause it sends back a 7-bit Manchester-encoded response that carries the application's 4-bit input nibble.

A small host port gives the application access to the node. The application writes the input nibble that later responses will carry. It reads the latest output nibble, and it watches a sticky flag that marks a completed exchange. The length of one bit time is an input counted in system clocks, so one netlist can serve several line rates. The node address is an input held by the surrounding logic.

Top module: `sabus_slave`

## Requirements
- R1: Bit encoding is Manchester II. A 1 is sent high then low, and a 0 is sent low then high, each half lasting half a bit time. An idle line is high. If a received bit has no level change at mid-bit, the frame is dropped and no response follows.
- R2: A call is 14 bits, sent first to last as: start bit, control bit, address A4..A0 (A4 first), information bits I4..I0 (I4 first), parity bit, end bit.
- R3: The parity bit makes the count of ones even over the bits from the control bit through the parity bit. A call with a parity error is dropped silently.
- R4: A valid call has a start bit of 0 and an end bit of 1. A call with a wrong end-bit level is dropped silently.
- R5: A call counts as a data exchange only when I4 is 0 and its address equals `nodeAddr`. Any other call gets no response and leaves `rdNibble` and `exFlag` unchanged.
- R6: A node whose `nodeAddr` is 0 never answers a call, including a call to address 0.
- R7: After a fully valid matching call, `rdNibble` takes the call's I3..I0. It changes at no other time and is 0 after reset.
- R8: The response starts 3 bit times after the end of the call, allowing a few clocks of input latency. It is 7 bits, sent as: start bit 0, I3..I0 (I3 first), an even parity bit over I3..I0, and end bit 1. Outside a response `txLine` is high.
- R9: `hostWrEn` stores `hostWrData` as the input nibble. A response carries the value held when its call was accepted, so a write made during the pause or the response affects only later responses.
- R10: `exFlag` is set by each accepted exchange and stays set until a `hostRdEn` pulse clears it.
- R11: One bit time lasts `bitClocks` system clocks, which must be even and at least 8. A new call is only recognised after the line has been high for more than 1.5 bit times.
- R12: After reset, `txLine` is 1, `rdNibble` is 0, `exFlag` is 0 and the input nibble is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitClocks | input | BITCLK_W | System clocks per bus bit time |
| nodeAddr | input | ADDR_W | Address of this node, 0 when unconfigured |
| rxLine | input | 1 | Demodulated receive line level |
| txLine | output | 1 | Manchester response line, high when idle |
| hostWrEn | input | 1 | Write strobe for the input nibble |
| hostWrData | input | NIB_W | Input nibble to send on later responses |
| hostRdEn | input | 1 | Read strobe, clears the exchange flag |
| rdNibble | output | NIB_W | Output nibble from the last accepted call |
| exFlag | output | 1 | Sticky flag marking an accepted exchange |

## Verification
The embedded assertions check several rules on every cycle. The output nibble moves only on the control's accept strobe. That strobe appears only for a well-formed call addressed to a nonzero node. The flag follows the accept and read strobes. A missing mid-bit transition always sends the receiver into its quiet state, and every response begins with a low half. Only the bench's scenarios can show the things that need whole frames. These are the exact bit order and parity of the response, the length of the pause, the silent dropping of parity, end-bit, I4 and address failures, the effect of a host write made during a response, and correct operation at a different bit time.

// File: rtl/sabus_pkg.sv
package sabus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_PAUSE,
    ST_TX,
    ST_QUIET
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // push one decoded bit into the call register
    logic shiftVal;  // value of that bit
    logic latchOut;  // accept call: capture output nibble, set flag
    logic loadTx;    // build the response frame
    logic shiftTx;   // advance to the next response bit
    logic txOn;      // response is on the line
    logic txSecond;  // second half of the current response bit
  } ctlStrobe_t;

endpackage

// File: rtl/sabus_datapath.sv
module sabus_datapath
  import sabus_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  logic [ADDR_W-1:0] nodeAddr,
  input  logic              hostWrEn,
  input  logic [NIB_W-1:0]  hostWrData,
  input  logic              hostRdEn,
  input  ctlStrobe_t        ctl,
  output logic              rxLevel,
  output logic              rxFall,
  output logic              frameOk,
  output logic              callHit,
  output logic              txLine,
  output logic [NIB_W-1:0]  rdNibble,
  output logic              exFlag
);

  localparam int CALL_W = ADDR_W + NIB_W + 5;
  localparam int RESP_W = NIB_W + 3;
  localparam int A_MSB  = CALL_W - 3;
  localparam int I_MSB  = A_MSB - ADDR_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrev;
  logic [CALL_W-1:0]      callSr;
  logic [RESP_W-1:0]      txSr;
  logic [NIB_W-1:0]       outReg;
  logic [NIB_W-1:0]       inReg;
  logic                   flagReg;
  logic [ADDR_W-1:0]      addrField;
  logic [NIB_W:0]         infoField;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ  <= '1;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxLine};
      rxPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rxLevel = syncQ[SYNC_STAGES-1];
  assign rxFall  = rxPrev & ~rxLevel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) callSr <= '1;
    else if (ctl.shiftIn) callSr <= {callSr[CALL_W-2:0], ctl.shiftVal};
  end

  assign addrField = callSr[A_MSB -: ADDR_W];
  assign infoField = callSr[I_MSB -: NIB_W+1];
  assign frameOk   = ~callSr[CALL_W-1] & callSr[0] & ~(^callSr[CALL_W-2:1]);
  assign callHit   = (addrField == nodeAddr) && (nodeAddr != '0) && !infoField[NIB_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg  <= '0;
      inReg   <= '0;
      flagReg <= 1'b0;
      txSr    <= '1;
    end else begin
      if (ctl.latchOut) outReg <= infoField[NIB_W-1:0];
      if (hostWrEn) inReg <= hostWrData;
      if (ctl.latchOut) flagReg <= 1'b1;
      else if (hostRdEn) flagReg <= 1'b0;
      if (ctl.loadTx) txSr <= {1'b0, inReg, ^inReg, 1'b1};
      else if (ctl.shiftTx) txSr <= {txSr[RESP_W-2:0], 1'b1};
    end
  end

  assign txLine   = ctl.txOn ? (txSr[RESP_W-1] ^ ctl.txSecond) : 1'b1;
  assign rdNibble = outReg;
  assign exFlag   = flagReg;

  // R7: output nibble moves only on an accept strobe
  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.latchOut |=> $stable(rdNibble));
  // R5 / R6: accept only a well-formed call to this nonzero address
  p_accept_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.latchOut |-> (frameOk && addrField == nodeAddr && !infoField[NIB_W]));
  p_addr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.latchOut |-> (nodeAddr != '0));
  // R10: flag set by accept, cleared by read
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.latchOut |=> exFlag);
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRdEn && !ctl.latchOut) |=> !exFlag);
  // R8: every response opens with the low half of a 0 start bit
  p_resp_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.txOn) |-> !txLine);

endmodule

// File: rtl/sabus_control.sv
module sabus_control
  import sabus_pkg::*;
#(
  parameter int BITCLK_W   = 8,
  parameter int CALL_BITS  = 14,
  parameter int RESP_BITS  = 7,
  parameter int PAUSE_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BITCLK_W-1:0] bitClocks,
  input  logic                rxLevel,
  input  logic                rxFall,
  input  logic                frameOk,
  input  logic                callHit,
  output ctlStrobe_t          ctl
);

  localparam int CNT_W = $clog2(CALL_BITS + 1);

  ctlState_t           state;
  logic [BITCLK_W-1:0] clkCnt;
  logic [CNT_W-1:0]    bitCnt;
  logic                firstHalf;
  logic [BITCLK_W:0]   quietCnt;

  logic [BITCLK_W-1:0] halfB, sampA, sampB, lastClk;
  logic [BITCLK_W:0]   quietLim;
  logic                bitEnd, accept, manErr;

  assign halfB    = bitClocks >> 1;
  assign sampA    = halfB >> 1;
  assign sampB    = halfB + sampA;
  assign lastClk  = bitClocks - 1'b1;
  assign quietLim = {1'b0, bitClocks} + {1'b0, halfB};
  assign bitEnd   = (clkCnt == lastClk);
  assign accept   = frameOk && callHit;
  assign manErr   = (state == ST_RX) && (clkCnt == sampB) && (rxLevel == firstHalf);

  always_comb begin
    ctl          = '0;
    ctl.txOn     = (state == ST_TX);
    ctl.txSecond = (clkCnt >= halfB);
    ctl.shiftVal = firstHalf;
    if (state == ST_RX && clkCnt == sampB && !manErr) ctl.shiftIn = 1'b1;
    if (state == ST_RX && bitEnd && bitCnt == CNT_W'(CALL_BITS-1) && accept) begin
      ctl.latchOut = 1'b1;
      ctl.loadTx   = 1'b1;
    end
    if (state == ST_TX && bitEnd) ctl.shiftTx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_QUIET;
      clkCnt    <= '0;
      bitCnt    <= '0;
      firstHalf <= 1'b1;
      quietCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          clkCnt <= '0;
          bitCnt <= '0;
          if (rxFall) begin
            state  <= ST_RX;
            clkCnt <= BITCLK_W'(1);
          end
        end
        ST_RX: begin
          if (clkCnt == sampA) firstHalf <= rxLevel;
          if (manErr) begin
            state    <= ST_QUIET;
            quietCnt <= '0;
          end else if (bitEnd) begin
            clkCnt <= '0;
            if (bitCnt == CNT_W'(CALL_BITS-1)) begin
              bitCnt   <= '0;
              quietCnt <= '0;
              state    <= accept ? ST_PAUSE : ST_QUIET;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        ST_PAUSE, ST_TX: begin
          if (bitEnd) begin
            clkCnt <= '0;
            if (state == ST_PAUSE && bitCnt == CNT_W'(PAUSE_BITS-1)) begin
              bitCnt <= '0;
              state  <= ST_TX;
            end else if (state == ST_TX && bitCnt == CNT_W'(RESP_BITS-1)) begin
              bitCnt   <= '0;
              quietCnt <= '0;
              state    <= ST_QUIET;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        default: begin
          if (!rxLevel) quietCnt <= '0;
          else if (quietCnt >= quietLim) state <= ST_IDLE;
          else quietCnt <= quietCnt + 1'b1;
        end
      endcase
    end
  end

  // R1: a bit with no mid-bit change abandons the frame
  p_man_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
    manErr |=> (state == ST_QUIET));
  // R11: no bit is taken from the line while answering
  p_no_rx_in_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE || state == ST_TX) |-> !ctl.shiftIn);

endmodule

// File: rtl/sabus_slave.sv
module sabus_slave
  import sabus_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NIB_W    = 4,
  parameter int BITCLK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BITCLK_W-1:0] bitClocks,
  input  logic [ADDR_W-1:0]   nodeAddr,
  input  logic                rxLine,
  output logic                txLine,
  input  logic                hostWrEn,
  input  logic [NIB_W-1:0]    hostWrData,
  input  logic                hostRdEn,
  output logic [NIB_W-1:0]    rdNibble,
  output logic                exFlag
);

  localparam int CALL_BITS  = ADDR_W + NIB_W + 5;
  localparam int RESP_BITS  = NIB_W + 3;
  localparam int PAUSE_BITS = 3;

  ctlStrobe_t ctl;
  logic rxLevel, rxFall, frameOk, callHit;

  sabus_control #(
    .BITCLK_W(BITCLK_W), .CALL_BITS(CALL_BITS),
    .RESP_BITS(RESP_BITS), .PAUSE_BITS(PAUSE_BITS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .bitClocks(bitClocks),
    .rxLevel(rxLevel), .rxFall(rxFall), .frameOk(frameOk),
    .callHit(callHit), .ctl(ctl)
  );

  sabus_datapath #(
    .ADDR_W(ADDR_W), .NIB_W(NIB_W), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .nodeAddr(nodeAddr),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .ctl(ctl), .rxLevel(rxLevel), .rxFall(rxFall), .frameOk(frameOk),
    .callHit(callHit), .txLine(txLine), .rdNibble(rdNibble), .exFlag(exFlag)
  );

endmodule

// File: tb/sim_sabus_slave.sv
module sim_sabus_slave;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bitClocks;
  logic [4:0] nodeAddr;
  logic       rxLine = 1'b1;
  logic       txLine;
  logic       hostWrEn = 1'b0;
  logic [3:0] hostWrData = '0;
  logic       hostRdEn = 1'b0;
  logic [3:0] rdNibble;
  logic       exFlag;

  int  bt = 16;
  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;
  logic [3:0] expOut = '0;
  logic [3:0] expIn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sabus_slave u0 (
    .clk(clk), .rst_n(rst_n), .bitClocks(bitClocks), .nodeAddr(nodeAddr),
    .rxLine(rxLine), .txLine(txLine), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .rdNibble(rdNibble),
    .exFlag(exFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] makeCall(input logic cb, input logic [4:0] addr,
                                           input logic [4:0] info, input logic badPar,
                                           input logic endBit);
    logic par;
    par = (^{cb, addr, info}) ^ badPar;
    return {1'b0, cb, addr, info, par, endBit};
  endfunction

  function automatic logic [6:0] makeResp(input logic [3:0] nib);
    return {1'b0, nib, ^nib, 1'b1};
  endfunction

  task automatic sendHalf(input logic lvl);
    rxLine = lvl;
    repeat (bt/2) @(negedge clk);
  endtask

  task automatic sendCall(input logic [13:0] bits, input int flatIdx);
    for (int i = 13; i >= 0; i--) begin
      sendHalf(bits[i]);
      sendHalf(i == flatIdx ? bits[i] : ~bits[i]);
    end
    rxLine = 1'b1;
  endtask

  task automatic hostWrite(input logic [3:0] v);
    hostWrEn = 1'b1; hostWrData = v;
    @(negedge clk);
    hostWrEn = 1'b0;
    expIn = v;
  endtask

  task automatic hostRead();
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic expectResponse(input logic [3:0] nib, input string tag,
                                input bit doWrite, input logic [3:0] wrVal);
    int waitC = 0;
    bit seen = 0;
    bit manOk = 1;
    logic [6:0] got = '0;
    logic h1, h2;
    while (waitC < 6*bt && !seen) begin
      @(negedge clk);
      waitC++;
      if (doWrite && waitC == 8) begin
        hostWrEn = 1'b1; hostWrData = wrVal;
        @(negedge clk);
        waitC++;
        hostWrEn = 1'b0;
        expIn = wrVal;
      end
      if (txLine == 1'b0) seen = 1;
    end
    check(seen, {tag, " R8 response start"}, seen, 1);
    check(waitC >= 3*bt - 2 && waitC <= 3*bt + 6, {tag, " R8 pause length"}, waitC, 3*bt);
    if (seen) begin
      for (int k = 0; k < 7; k++) begin
        repeat (bt/4) @(negedge clk);
        h1 = txLine;
        repeat (bt/2) @(negedge clk);
        h2 = txLine;
        repeat (bt/4) @(negedge clk);
        if (h1 == h2) manOk = 0;
        got = {got[5:0], h1};
      end
      check(manOk, {tag, " R1 response encoding"}, manOk, 1);
      check(got == makeResp(nib), {tag, " R8 response frame"}, got, makeResp(nib));
    end
    repeat (3*bt) @(negedge clk);
  endtask

  task automatic expectSilence(input string tag);
    bit quiet = 1;
    for (int i = 0; i < 12*bt; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1) quiet = 0;
    end
    check(quiet, {tag, " no response"}, quiet, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R11 actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    bitClocks = 8'(bt);
    nodeAddr  = 5'd5;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(txLine == 1'b1, "R12 txLine idle", txLine, 1);
    check(rdNibble == 4'h0, "R12 rdNibble reset", rdNibble, 0);
    check(exFlag == 1'b0, "R12 exFlag reset", exFlag, 0);
    rst_n = 1'b1;
    repeat (3*bt) @(negedge clk);

    // R12: input nibble resets to 0
    sendCall(makeCall(1'b0, 5'd5, 5'h07, 1'b0, 1'b1), -1);
    expectResponse(4'h0, "R12 reset input nibble", 1'b0, 4'h0);
    expOut = 4'h7;

    // R7 R9 R10: basic exchange
    hostWrite(4'hA);
    sendCall(makeCall(1'b0, 5'd5, 5'h03, 1'b0, 1'b1), -1);
    expectResponse(4'hA, "R9 basic", 1'b0, 4'h0);
    expOut = 4'h3;
    check(rdNibble == expOut, "R7 output nibble", rdNibble, expOut);
    check(exFlag == 1'b1, "R10 flag set", exFlag, 1);
    hostRead();
    check(exFlag == 1'b0, "R10 flag cleared", exFlag, 0);

    // R3 parity error
    sendCall(makeCall(1'b0, 5'd5, 5'h0C, 1'b1, 1'b1), -1);
    expectSilence("R3 parity");
    check(rdNibble == expOut && !exFlag, "R3 state kept", rdNibble, expOut);

    // R1 missing mid-bit transition
    sendCall(makeCall(1'b0, 5'd5, 5'h0C, 1'b0, 1'b1), 6);
    expectSilence("R1 flat bit");
    check(rdNibble == expOut && !exFlag, "R1 state kept", rdNibble, expOut);

    // R4 wrong end bit
    sendCall(makeCall(1'b0, 5'd5, 5'h0C, 1'b0, 1'b0), -1);
    expectSilence("R4 end bit");
    check(rdNibble == expOut && !exFlag, "R4 state kept", rdNibble, expOut);

    // R5 I4 set
    sendCall(makeCall(1'b0, 5'd5, 5'h1C, 1'b0, 1'b1), -1);
    expectSilence("R5 I4 set");
    check(rdNibble == expOut && !exFlag, "R5 I4 state kept", rdNibble, expOut);

    // R5 address mismatch
    sendCall(makeCall(1'b0, 5'd6, 5'h0C, 1'b0, 1'b1), -1);
    expectSilence("R5 mismatch");
    check(rdNibble == expOut && !exFlag, "R5 mismatch state kept", rdNibble, expOut);

    // R2 address bit order: node 0x12, reversed would be 0x09
    nodeAddr = 5'h12;
    sendCall(makeCall(1'b1, 5'h12, 5'h09, 1'b0, 1'b1), -1);
    expectResponse(expIn, "R2 order", 1'b0, 4'h0);
    expOut = 4'h9;
    check(rdNibble == expOut, "R2 info order", rdNibble, expOut);
    hostRead();
    sendCall(makeCall(1'b0, 5'h09, 5'h05, 1'b0, 1'b1), -1);
    expectSilence("R2 reversed addr");

    // R6 node address 0
    nodeAddr = 5'd0;
    sendCall(makeCall(1'b0, 5'd0, 5'h06, 1'b0, 1'b1), -1);
    expectSilence("R6 addr zero");
    check(rdNibble == expOut && !exFlag, "R6 state kept", rdNibble, expOut);

    // R9 write during pause affects only later responses
    nodeAddr = 5'd31;
    hostWrite(4'h5);
    sendCall(makeCall(1'b0, 5'd31, 5'h0E, 1'b0, 1'b1), -1);
    expectResponse(4'h5, "R9 write in pause", 1'b1, 4'hC);
    expOut = 4'hE;
    sendCall(makeCall(1'b0, 5'd31, 5'h01, 1'b0, 1'b1), -1);
    expectResponse(4'hC, "R9 next response", 1'b0, 4'h0);
    expOut = 4'h1;
    hostRead();

    // R5 R7 R10 random mix
    for (int it = 0; it < 16; it++) begin
      logic [4:0] na, ca, info;
      logic [3:0] wv;
      bit hit;
      na   = 5'($urandom_range(1, 31));
      ca   = ($urandom_range(0, 1) == 0) ? na : 5'($urandom_range(0, 31));
      info = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 2) != 0) info[4] = 1'b0;
      wv   = 4'($urandom_range(0, 15));
      nodeAddr = na;
      hostWrite(wv);
      hit = (ca == na) && !info[4];
      sendCall(makeCall(1'($urandom_range(0, 1)), ca, info, 1'b0, 1'b1), -1);
      if (hit) begin
        expectResponse(wv, "R5 random hit", 1'b0, 4'h0);
        expOut = info[3:0];
      end else begin
        expectSilence("R5 random miss");
      end
      check(rdNibble == expOut, "R7 random nibble", rdNibble, expOut);
      check(exFlag == hit, "R10 random flag", exFlag, hit);
      hostRead();
    end

    // R11 other bit time
    bt = 24;
    bitClocks = 8'(bt);
    nodeAddr = 5'd9;
    repeat (3*bt) @(negedge clk);
    hostWrite(4'h6);
    sendCall(makeCall(1'b0, 5'd9, 5'h0B, 1'b0, 1'b1), -1);
    expectResponse(4'h6, "R11 bit time 24", 1'b0, 4'h0);
    expOut = 4'hB;
    check(rdNibble == expOut, "R11 nibble", rdNibble, expOut);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule